// File: doc/BRIEF.md
# Multi-Source Sample Alignment Buffer

This block collects measurement samples from several independent sources. Each source is a merging unit that sends a stream of frames. A frame carries a sample counter, one channel value and a quality flag. Network and processing delays make frames from different sources arrive at different times. The block therefore stores each sample in a small per-source circular slot memory, indexed by the low bits of its counter. A local tick marks the nominal time of each successive sample. A fixed number of ticks after a sample's nominal time, the block releases one aligned set holding that counter's value from every source. It does not wait for slow sources. Each source's entry carries a flag that says whether a real sample was present.

The sample counter runs at 80 steps per power cycle and restarts at zero every second. Its modulus therefore follows a nominal-frequency select: 4000 steps at 50 Hz and 4800 steps at 60 Hz. The release lag is a 2 ms allowance rounded up to whole steps, which gives 8 ticks at 50 Hz and 10 ticks at 60 Hz. Frames that arrive after their counter has been released, or that aim too far into the future, are dropped. Each such drop increments a saturating counter for that source.

Top module: `stream_aligner`

## Requirements
- R1: The counter space holds 4000 values (0..3999) when `freq_60` is 0 and 4800 values (0..4799) when it is 1. Released counters step by one per release and wrap from the top value to 0.
- R2: Counting ticks from reset with the first as tick 1, tick k releases counter (k-1-D) modulo the space. D is 8 at 50 Hz and 10 at 60 Hz. Ticks 1..D release nothing.
- R3: In a released set, a source whose frame for that counter was accepted shows `out_ok` bit 1, and its `out_dat` field (source s at bits s*DW upward) holds that frame's value.
- R4: A source with no accepted frame for the released counter shows `out_ok` 0. Its data field holds the most recent value accepted from that source, or 0 if none has been accepted since reset.
- R5: A slot becomes empty on release. A counter that maps to the same slot one lap later shows `out_ok` 0 unless a new frame for it is accepted.
- R6: With P the next counter due for release, a good-quality frame is accepted only when its counter is below the modulus and (counter-P) modulo the space is below DEPTH (32). Any other good-quality frame is discarded and raises that source's `late_cnt` field by one. The field saturates at all ones.
- R7: A frame with its quality input low changes neither the stored samples, nor the last value, nor the late count.
- R8: `out_vld` is high for exactly the cycle after a releasing tick and low at all other times. `out_cnt` gives the released counter.
- R9: After reset, `out_vld`, `out_ok`, `out_dat` and every `late_cnt` field read 0.
- R10: A frame whose counter equals P, presented in the same cycle as a tick, counts as late and is not stored.
- R11: A second accepted frame for the same source and counter replaces the stored value before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_60 | input | 1 | Nominal frequency: 0 = 50 Hz, 1 = 60 Hz; held static outside reset |
| tick | input | 1 | One-cycle pulse at each nominal sample time |
| src_vld | input | N_SRC | Frame present, one bit per source |
| src_cnt | input | N_SRC*CW | Sample counter per source |
| src_dat | input | N_SRC*DW | Channel value per source |
| src_qok | input | N_SRC | Frame quality good, one bit per source |
| out_vld | output | 1 | Aligned set valid |
| out_cnt | output | CW | Counter of the released set |
| out_dat | output | N_SRC*DW | Aligned values, source s at bits s*DW upward |
| out_ok | output | N_SRC | Per-source sample present flag |
| late_cnt | output | N_SRC*LW | Saturating late/out-of-window drop count per source |

## Verification
The hardest case to reach is the boundary of the acceptance window at the moment a slot is released. That moment covers a frame for the counter being released in the same cycle as its tick, frames exactly one step too old, and frames just beyond the DEPTH lookahead. The stimulus chooses each source's counter from a random lag around the current tick position, spanning a few steps ahead to a few steps past the release point. It mixes in deliberate same-cycle release collisions, far-ahead counters and counters beyond the modulus. Runs of several thousand ticks at both frequencies carry the release pointer and slot reuse across the counter wrap.

// File: rtl/align_pkg.sv
package align_pkg;

  // (a - b) modulo m, both operands already below m
  function automatic int unsigned mod_sub(input int unsigned a, input int unsigned b,
                                          input int unsigned m);
    return (a >= b) ? (a - b) : (a + m - b);
  endfunction

  // a + 1 modulo m
  function automatic int unsigned mod_inc(input int unsigned a, input int unsigned m);
    return (a + 1 == m) ? 0 : a + 1;
  endfunction

  // latency allowance in whole sample steps, rounded up
  function automatic int unsigned delay_steps(input int unsigned hz, input int unsigned spc,
                                              input int unsigned us);
    return (us * hz * spc + 999999) / 1000000;
  endfunction

endpackage

// File: rtl/align_timebase.sv
module align_timebase
  import align_pkg::*;
#(
  parameter int CW  = 13,
  parameter int M50 = 4000,
  parameter int M60 = 4800,
  parameter int D50 = 8,
  parameter int D60 = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          freq_60,
  output logic [CW-1:0] modulus,
  output logic [CW-1:0] rel_ptr,
  output logic          fire
);

  logic [CW-1:0] dly;
  logic [CW-1:0] warm;

  assign modulus = freq_60 ? CW'(M60) : CW'(M50);
  assign dly     = freq_60 ? CW'(D60) : CW'(D50);
  assign fire    = tick && (warm == dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_ptr <= CW'(32'(modulus) - 32'(dly));
      warm    <= '0;
    end else if (tick) begin
      rel_ptr <= CW'(mod_inc(32'(rel_ptr), 32'(modulus)));
      if (warm != dly) warm <= warm + 1'b1;
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ptr < modulus);  // R1
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (rel_ptr == modulus - 1'b1) |=> rel_ptr == '0);  // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rel_ptr));  // R2

endmodule

// File: rtl/align_lane.sv
module align_lane
  import align_pkg::*;
#(
  parameter int CW    = 13,
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] modulus,
  input  logic [CW-1:0] rel_ptr,
  input  logic          tick,
  input  logic          in_vld,
  input  logic [CW-1:0] in_cnt,
  input  logic [DW-1:0] in_dat,
  input  logic          in_qok,
  output logic          rel_ok,
  output logic [DW-1:0] rel_dat,
  output logic [LW-1:0] late_cnt
);

  localparam int ASW = $clog2(DEPTH);
  localparam logic [LW-1:0] LMAX = '1;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] full;
  logic [DW-1:0]    last_val;
  logic [CW-1:0]    off;
  logic             in_range, hit, wr_en, drop;
  logic [ASW-1:0]   wr_slot, rel_slot;

  assign wr_slot  = in_cnt[ASW-1:0];
  assign rel_slot = rel_ptr[ASW-1:0];
  assign in_range = in_cnt < modulus;
  assign off      = CW'(mod_sub(32'(in_cnt), 32'(rel_ptr), 32'(modulus)));
  assign hit      = in_range && (off < CW'(DEPTH)) && !(tick && off == '0);
  assign wr_en    = in_vld && in_qok && hit;
  assign drop     = in_vld && in_qok && !hit;

  assign rel_ok  = full[rel_slot];
  assign rel_dat = full[rel_slot] ? mem[rel_slot] : last_val;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= in_dat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= '0;
      last_val <= '0;
      late_cnt <= '0;
    end else begin
      if (tick) full[rel_slot] <= 1'b0;
      if (wr_en) begin
        full[wr_slot] <= 1'b1;
        last_val      <= in_dat;
      end
      if (drop && late_cnt != LMAX) late_cnt <= late_cnt + 1'b1;
    end
  end

  AST_WRITE_AVOIDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && wr_en |-> wr_slot != rel_slot);  // R10
  AST_LATE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> late_cnt >= $past(late_cnt));  // R6
  AST_LATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    drop && late_cnt != LMAX |=> late_cnt == $past(late_cnt) + 1'b1);  // R6
  AST_BADQ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !in_qok |=> $stable(last_val) && $stable(late_cnt));  // R7

endmodule

// File: rtl/stream_aligner.sv
module stream_aligner
  import align_pkg::*;
#(
  parameter int N_SRC    = 3,
  parameter int CW       = 13,
  parameter int DW       = 16,
  parameter int LW       = 8,
  parameter int DEPTH    = 32,
  parameter int SPC      = 80,
  parameter int DELAY_US = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                freq_60,
  input  logic                tick,
  input  logic [N_SRC-1:0]    src_vld,
  input  logic [N_SRC*CW-1:0] src_cnt,
  input  logic [N_SRC*DW-1:0] src_dat,
  input  logic [N_SRC-1:0]    src_qok,
  output logic                out_vld,
  output logic [CW-1:0]       out_cnt,
  output logic [N_SRC*DW-1:0] out_dat,
  output logic [N_SRC-1:0]    out_ok,
  output logic [N_SRC*LW-1:0] late_cnt
);

  localparam int M50 = 50 * SPC;
  localparam int M60 = 60 * SPC;
  localparam int D50 = int'(delay_steps(50, SPC, DELAY_US));
  localparam int D60 = int'(delay_steps(60, SPC, DELAY_US));

  logic [CW-1:0]       modulus, rel_ptr;
  logic                fire;
  logic [N_SRC-1:0]    lane_ok;
  logic [N_SRC*DW-1:0] lane_dat;

  align_timebase #(.CW(CW), .M50(M50), .M60(M60), .D50(D50), .D60(D60)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freq_60(freq_60),
    .modulus(modulus), .rel_ptr(rel_ptr), .fire(fire)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_lane
    align_lane #(.CW(CW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n), .modulus(modulus), .rel_ptr(rel_ptr), .tick(tick),
      .in_vld(src_vld[s]), .in_cnt(src_cnt[s*CW +: CW]), .in_dat(src_dat[s*DW +: DW]),
      .in_qok(src_qok[s]), .rel_ok(lane_ok[s]), .rel_dat(lane_dat[s*DW +: DW]),
      .late_cnt(late_cnt[s*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_cnt <= '0;
      out_dat <= '0;
      out_ok  <= '0;
    end else begin
      out_vld <= fire;
      if (fire) begin
        out_cnt <= rel_ptr;
        out_dat <= lane_dat;
        out_ok  <= lane_ok;
      end
    end
  end

  AST_OUT_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(tick));  // R8
  AST_OUT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_cnt < modulus);  // R1

endmodule

// File: tb/stream_aligner_bench.sv
module stream_aligner_bench;
  localparam int N = 3, CW = 13, DW = 16, LW = 4, DEPTH = 32;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 0, rst_n = 0, freq_60 = 0, tick = 0;
  logic [N-1:0] src_vld = '0, src_qok = '0;
  logic [N*CW-1:0] src_cnt;
  logic [N*DW-1:0] src_dat;
  logic out_vld;
  logic [CW-1:0] out_cnt;
  logic [N*DW-1:0] out_dat;
  logic [N-1:0] out_ok;
  logic [N*LW-1:0] late_cnt;

  int drv_c [N];
  logic [DW-1:0] drv_d [N];

  always #4 clk = ~clk;

  always_comb begin
    for (int s = 0; s < N; s++) begin
      src_cnt[s*CW +: CW] = CW'(drv_c[s]);
      src_dat[s*DW +: DW] = drv_d[s];
    end
  end

  stream_aligner #(.N_SRC(N), .CW(CW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) u_stream_aligner (
    .clk(clk), .rst_n(rst_n), .freq_60(freq_60), .tick(tick),
    .src_vld(src_vld), .src_cnt(src_cnt), .src_dat(src_dat), .src_qok(src_qok),
    .out_vld(out_vld), .out_cnt(out_cnt), .out_dat(out_dat), .out_ok(out_ok),
    .late_cnt(late_cnt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int M, D, relp, kt;
  bit efill [N][4800];
  logic [DW-1:0] edat [N][4800];
  logic [DW-1:0] elast [N];
  int elate [N];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit f60);
    @(negedge clk);
    rst_n = 0; freq_60 = f60; tick = 0; src_vld = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    M = f60 ? 4800 : 4000;
    D = f60 ? 10 : 8;
    relp = M - D; kt = 0;
    for (int s = 0; s < N; s++) begin
      elast[s] = '0; elate[s] = 0;
      for (int c = 0; c < 4800; c++) efill[s][c] = 0;
    end
    chk(out_vld == 0, "R9 out_vld", out_vld, 0);
    chk(out_ok == 0, "R9 out_ok", out_ok, 0);
    chk(out_dat == 0, "R9 out_dat", out_dat, 0);
    chk(late_cnt == 0, "R9 late_cnt", late_cnt, 0);
  endtask

  // one cycle: frames already in drv_* / src_vld / src_qok, optional tick
  task automatic cycle(input bit tk);
    bit fire;
    bit eok [N];
    logic [DW-1:0] eout [N];
    int ecnt;
    fire = tk && (kt >= D);
    ecnt = relp;
    if (tk) begin
      for (int s = 0; s < N; s++) begin
        eok[s]  = efill[s][relp];
        eout[s] = eok[s] ? edat[s][relp] : elast[s];
      end
    end
    for (int s = 0; s < N; s++) begin
      if (src_vld[s] && src_qok[s]) begin
        int off;
        bit acc;
        off = (drv_c[s] < M) ? ((drv_c[s] - relp + M) % M) : 9999;
        acc = (off < DEPTH) && !(tk && off == 0);
        if (acc) begin
          efill[s][drv_c[s]] = 1;
          edat[s][drv_c[s]]  = drv_d[s];
          elast[s] = drv_d[s];
        end else if (elate[s] < LMAX) elate[s]++;
      end
    end
    if (tk) begin
      for (int s = 0; s < N; s++) efill[s][relp] = 0;
      relp = (relp + 1) % M;
      kt++;
    end
    tick = tk;
    @(negedge clk);
    tick = 0; src_vld = '0; src_qok = '0;
    chk(out_vld == fire, "R8 R2 out_vld", out_vld, fire);
    if (fire) begin
      chk(out_cnt == CW'(ecnt), "R1 R2 out_cnt", out_cnt, ecnt);
      for (int s = 0; s < N; s++) begin
        chk(out_ok[s] == eok[s], "R3 R4 R5 out_ok", out_ok[s], eok[s]);
        chk(out_dat[s*DW +: DW] == eout[s], "R3 R4 R11 out_dat", out_dat[s*DW +: DW], eout[s]);
      end
    end
    for (int s = 0; s < N; s++)
      chk(late_cnt[s*LW +: LW] == LW'(elate[s]), "R6 R7 R10 late_cnt",
          late_cnt[s*LW +: LW], elate[s]);
  endtask

  task automatic run(input bit f60, input int steps);
    do_reset(f60);
    for (int k = 0; k < steps; k++) begin
      for (int s = 0; s < N; s++) begin
        int lag, r;
        lag = int'($urandom_range(0, D + 7)) - 3;
        r = int'($urandom_range(0, 99));
        src_vld[s] = ($urandom_range(0, 9) != 0);
        src_qok[s] = ($urandom_range(0, 19) != 0);
        drv_d[s] = DW'($urandom);
        if (r < 3) drv_c[s] = M + int'($urandom_range(0, 100));
        else if (r < 6) drv_c[s] = (relp + DEPTH + int'($urandom_range(0, 40))) % M;
        else drv_c[s] = (((kt - 1 - lag) % M) + M) % M;
      end
      cycle(0);
      if ($urandom_range(0, 9) == 0) begin  // R11 overwrite of a pending counter
        drv_c[1] = (relp + 2) % M; drv_d[1] = DW'($urandom);
        src_vld[1] = 1; src_qok[1] = 1;
        cycle(0);
        drv_d[1] = DW'($urandom); src_vld[1] = 1; src_qok[1] = 1;
        cycle(0);
      end
      if ($urandom_range(0, 11) == 0) begin  // R10 collision with release
        drv_c[0] = relp; drv_d[0] = DW'($urandom);
        src_vld[0] = 1; src_qok[0] = 1;
      end
      cycle(1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < N; s++) begin drv_c[s] = 0; drv_d[s] = '0; end
    run(0, 4100);   // R1 wrap at 3999
    run(1, 4900);   // R1 wrap at 4799
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule